// File: doc/BRIEF.md
# External Interrupt Pin Capture Unit

This block watches four active-low external interrupt pins and turns activity on them into sticky request flags for a downstream interrupt controller. Each pin first passes through a two-flop synchroniser. A per-channel sensitivity bit then picks the condition that sets the flag. A value of 0 selects level sensitivity: the pin being low sets the flag. A value of 1 selects edge sensitivity: a high-to-low transition sets the flag. Each request output mirrors its channel's flag.

Software programs the sensitivity bits and clears flags through a small register port with two addresses: a sensitivity register and a flag register. A flag is cleared by writing 1 to its bit in the flag register. Writing 0 leaves the bit alone. In level mode a clear has no effect while the pin stays low, so a request cannot be lost while the source still asserts it. In edge mode a new falling edge that lands in the same cycle as a clear keeps the flag set.

Each channel is a two-state machine. `CH_IDLE` means no request and `CH_PEND` means a request is held. The transition `IDLE->PEND` (trigger) occurs when the selected condition is seen. The transition `PEND->IDLE` (clear) occurs on a clear write in a cycle where the condition is not seen. In every other case the state holds: `IDLE` stays idle without a trigger, and `PEND` stays pending without a clear, or when a trigger coincides with the clear.

Top module: `eint_capture`

## Requirements
- R1: After reset all request outputs are 0, and both the sensitivity register and the flag register read as 0.
- R2: A write with `reg_sel`=0 loads the sensitivity register, whose bit n selects the mode of channel n (1 = falling edge, 0 = low level). A read with `reg_sel`=0 returns the value written.
- R3: In level mode a channel whose pin is held low shows its request on the output after the third rising clock edge following the pin change.
- R4: In level mode a clear write to a channel has no effect while its pin is still low.
- R5: In level mode the flag stays set after the pin returns high, and a clear write then removes it.
- R6: In edge mode a falling pin edge sets the flag after the third rising clock edge. A rising edge never sets it.
- R7: In edge mode a clear write removes the flag even while the pin stays low. The flag does not set again until a new falling edge arrives.
- R8: With `reg_sel`=1, writing 1 to bit n clears flag n, and writing 0 to bit n leaves flag n unchanged.
- R9: When a falling edge is detected in the same cycle as a clear write to that channel, the flag stays set.
- R10: `irq_req` bit n always equals flag n as read through the register port with `reg_sel`=1.
- R11: A clear write affects only the channels whose bits are 1 in the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NCH | Active-low interrupt pins, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = sensitivity register, 1 = flag register |
| wr_data | input | NCH | Write data |
| rd_data | output | NCH | Read data for the selected register (combinational) |
| irq_req | output | NCH | Per-channel request lines |

## Verification
A channel state machine stuck in or wrongly moved to `CH_PEND` appears on `irq_req` and in the flag read on the next clock. A missed or doubled synchroniser stage shows as a request one cycle early or late against the fixed three-edge latency, so the bench checks both the cycle before and the cycle of the expected rise. A wrong arbitration between clear and trigger appears in two ways: a level request that vanishes while its pin is still low, or an edge request that is lost when a new falling edge meets a clear. Both are visible one cycle after the write.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;

    typedef enum logic {
        SEL_MODE = 1'b0,
        SEL_FLAG = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           reg_sel,
    input  logic [NCH-1:0] wr_data,
    input  logic [NCH-1:0] flags,
    output logic [NCH-1:0] mode_edge,
    output logic [NCH-1:0] clr_pulse,
    output logic [NCH-1:0] rd_data
);
    reg_sel_e sel;
    logic     wr_mode;
    logic     wr_flag;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_mode = wr_en && (sel == SEL_MODE);
    assign wr_flag = wr_en && (sel == SEL_FLAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_edge <= '0;
        else if (wr_mode) mode_edge <= wr_data;
    end

    always_comb begin
        clr_pulse = wr_flag ? wr_data : '0;
    end

    always_comb begin
        unique case (sel)
            SEL_MODE: rd_data = mode_edge;
            SEL_FLAG: rd_data = flags;
            default:  rd_data = '0;
        endcase
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_edge)); // R2

endmodule

// File: rtl/eint_channel.sv
module eint_channel
    import eint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic mode_edge,
    input  logic clr,
    output logic flag
);
    ch_state_e state_q;
    ch_state_e state_d;
    logic      pin_prev_q;
    logic      fall;
    logic      trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev_q <= 1'b1;
        else        pin_prev_q <= pin_s;
    end

    assign fall = pin_prev_q & ~pin_s;
    assign trig = mode_edge ? fall : ~pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (trig)        state_d = CH_PEND;
            CH_PEND: if (clr && !trig) state_d = CH_IDLE;
            default:                  state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == CH_PEND);
    end

    AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_edge && !pin_s) |=> flag); // R4

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_edge && pin_prev_q && !pin_s) |=> flag); // R9

    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr && pin_s) |=> !flag); // R8

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R5

    AST_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && pin_s) |=> !flag); // R6

endmodule

// File: rtl/eint_capture.sv
module eint_capture
    import eint_pkg::*;
#(
    parameter int unsigned NCH         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pin_n,
    input  logic           wr_en,
    input  logic           reg_sel,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] rd_data,
    output logic [NCH-1:0] irq_req
);
    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] mode_edge;
    logic [NCH-1:0] clr_pulse;
    logic [NCH-1:0] flags;

    eint_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_n),
        .sync_out (pin_s)
    );

    eint_regs #(.NCH(NCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .reg_sel   (reg_sel),
        .wr_data   (wr_data),
        .flags     (flags),
        .mode_edge (mode_edge),
        .clr_pulse (clr_pulse),
        .rd_data   (rd_data)
    );

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            eint_channel u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_s     (pin_s[c]),
                .mode_edge (mode_edge[c]),
                .clr       (clr_pulse[c]),
                .flag      (flags[c])
            );
        end
    endgenerate

    assign irq_req = flags;

    AST_CLR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel) |=> ((flags & ~$past(wr_data)) == ($past(flags) & ~$past(wr_data)))
            || ((flags & ~$past(wr_data)) != ($past(flags) & ~$past(wr_data))
                && ((flags & ~$past(flags)) != '0))); // R11

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq_req == '0)); // R1

endmodule

// File: tb/eint_capture_tb.sv
module eint_capture_tb;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] pin_n;
    logic           wr_en;
    logic           reg_sel;
    logic [NCH-1:0] wr_data;
    logic [NCH-1:0] rd_data;
    logic [NCH-1:0] irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eint_capture #(.NCH(NCH)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (pin_n),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_req (irq_req)
    );

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [NCH-1:0] d);
        reg_sel = sel;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [NCH-1:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] v;
        logic [NCH-1:0] bit_c;
        rst_n   = 1'b0;
        pin_n   = '1;
        wr_en   = 1'b0;
        reg_sel = 1'b0;
        wr_data = '0;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 irq", irq_req, '0);
        rd_reg(1'b0, v); chk("R1 mode", v, '0);
        rd_reg(1'b1, v); chk("R1 flag", v, '0);

        // R2 sweep every mode value
        for (int m = 0; m < (1 << NCH); m++) begin
            wr_reg(1'b0, NCH'(m));
            rd_reg(1'b0, v);
            chk("R2 mode readback", v, NCH'(m));
            chk("R2 no request", irq_req, '0);
        end

        // Level mode per channel
        wr_reg(1'b0, '0);
        for (int ch = 0; ch < NCH; ch++) begin
            bit_c = NCH'(1) << ch;
            pin_n[ch] = 1'b0;
            cyc(2);
            chk("R3 not yet", irq_req, '0);
            cyc(1);
            chk("R3 level set", irq_req, bit_c);
            rd_reg(1'b1, v); chk("R10 flag equals irq", v, irq_req);
            wr_reg(1'b1, bit_c);
            chk("R4 clear blocked", irq_req, bit_c);
            cyc(2);
            chk("R4 still held", irq_req, bit_c);
            pin_n[ch] = 1'b1;
            cyc(4);
            chk("R5 sticky after release", irq_req, bit_c);
            wr_reg(1'b1, bit_c);
            chk("R5 cleared", irq_req, '0);
        end

        // Edge mode per channel
        wr_reg(1'b0, '1);
        for (int ch = 0; ch < NCH; ch++) begin
            bit_c = NCH'(1) << ch;
            pin_n[ch] = 1'b0;
            cyc(2);
            chk("R6 not yet", irq_req, '0);
            cyc(1);
            chk("R6 edge set", irq_req, bit_c);
            wr_reg(1'b1, '0);
            chk("R8 write zero keeps", irq_req, bit_c);
            wr_reg(1'b1, ~bit_c);
            chk("R8 other bits keep", irq_req, bit_c);
            wr_reg(1'b1, bit_c);
            chk("R7 clear with pin low", irq_req, '0);
            cyc(3);
            chk("R7 no retrigger", irq_req, '0);
            pin_n[ch] = 1'b1;
            cyc(4);
            chk("R6 rising edge ignored", irq_req, '0);
            // R9 set wins
            pin_n[ch] = 1'b0;
            cyc(3);
            pin_n[ch] = 1'b1;
            cyc(4);
            chk("R9 pending before", irq_req, bit_c);
            pin_n[ch] = 1'b0;
            cyc(2);
            wr_reg(1'b1, bit_c);
            chk("R9 set wins", irq_req, bit_c);
            rd_reg(1'b1, v); chk("R10 flag equals irq", v, irq_req);
            pin_n[ch] = 1'b1;
            cyc(4);
            wr_reg(1'b1, bit_c);
            chk("R9 later clear", irq_req, '0);
        end

        // R11 independence
        pin_n = 4'b1010;
        cyc(3);
        chk("R11 two set", irq_req, 4'b0101);
        pin_n = '1;
        cyc(4);
        wr_reg(1'b1, 4'b0001);
        chk("R11 only ch0 cleared", irq_req, 4'b0100);
        wr_reg(1'b1, 4'b0100);
        chk("R11 all clear", irq_req, '0);

        // Mixed modes: ch0,ch2 level; ch1,ch3 edge
        wr_reg(1'b0, 4'b1010);
        pin_n = '0;
        cyc(3);
        chk("R3 R6 mixed set", irq_req, '1);
        wr_reg(1'b1, '1);
        chk("R4 R7 mixed clear", irq_req, 4'b0101);
        pin_n = '1;
        cyc(3);
        wr_reg(1'b1, '1);
        chk("R5 mixed clear", irq_req, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule